// File: doc/BRIEF.md
# I2C Slave Receive Engine with Selectable Wait and Acknowledge Points

This block is the receive side of an I2C slave. It samples the bus clock and data lines through a synchronizer clocked by the system clock. It detects start and stop conditions and shifts in the address byte and each data byte that follows. The address byte is compared against a programmed local address. An address byte whose upper five bits are `11110` is treated as an extension code. Both bus lines are open-drain, so each is modelled as a sampled input plus a drive-low output.

Three control inputs decide what happens around the end of each byte.

- **Wait point select** places the clock stretch and the interrupt pulse at the 8th or the 9th falling clock edge of a data byte.
- **Acknowledge enable** decides whether SDA is pulled low for the 9th clock.
- **Stop-interrupt enable** decides whether a stop condition raises an interrupt.

The address byte follows fixed rules of its own that override these inputs. While the block holds SCL low, software inspects the received byte and may change the acknowledge choice. Software then pulses the release input to let the transfer continue.

Top module: `i2c_slave_waitack`

## Requirements
- R1: After reset, and after every start or repeated start, no bus line is driven and no interrupt is pending. The next eight received bits form an address byte.
- R2: An address byte whose upper seven bits equal the local address and whose lowest bit (read/write) is 0 is acknowledged automatically, whatever the acknowledge enable is. SDA is driven low from the 8th falling edge to the 9th falling edge. An interrupt pulse is raised at the 9th falling edge and SCL is held low from that edge, whatever the wait point select is. Subsequent bytes are data bytes.
- R3: An address byte that neither matches nor starts with `11110` gets no acknowledge, no interrupt and no stretch. Every byte that follows is ignored until the next start.
- R4: An extension-code address byte (upper bits `11110`) raises an interrupt and holds SCL low from its 8th falling edge. The acknowledge for its 9th clock takes the acknowledge-enable value present at release. SDA and SCL are never both driven low by the block.
- R5: For a data byte with wait point select 0, an interrupt is raised and SCL is held low at the 8th falling edge. The acknowledge takes the acknowledge-enable value present at release. Nothing is raised at the 9th falling edge.
- R6: For a data byte with wait point select 1, SDA is driven low from the 8th falling edge to the 9th falling edge if acknowledge enable is 1. An interrupt is raised and SCL is held low at the 9th falling edge.
- R7: Once SCL is held low, it stays held until the release input is pulsed. An interrupt pulse lasts one cycle, and each new stretch begins together with one.
- R8: A stop condition returns the block to idle and raises a one-cycle interrupt if and only if stop-interrupt enable is 1.
- R9: While the interface enable is 0, the block drives neither line and raises no interrupt, whatever happens on the bus.
- R10: A start condition in the middle of a byte discards the partial byte. The address byte after it is counted from its first bit.
- R11: The received-byte output presents the most recent complete byte, address or data, from its 8th falling edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| if_enable | input | 1 | Interface enable; 0 holds the engine idle |
| wait_on_ninth | input | 1 | Data-byte wait point: 0 = 8th falling edge, 1 = 9th |
| ack_enable | input | 1 | Acknowledge data and extension-code bytes |
| stop_irq_enable | input | 1 | Raise an interrupt on stop condition |
| local_addr | input | ADDR_W | Own 7-bit slave address |
| release_i | input | 1 | One-cycle pulse ending a clock stretch |
| scl_i | input | 1 | Sampled SCL bus level |
| sda_i | input | 1 | Sampled SDA bus level |
| scl_drive_low_o | output | 1 | Pull SCL low (clock stretch) |
| sda_drive_low_o | output | 1 | Pull SDA low (acknowledge) |
| irq_o | output | 1 | One-cycle interrupt pulse |
| rx_byte_o | output | ADDR_W+1 | Last complete received byte |

## Verification
The hardest case to reach from the ports is an acknowledge that is decided only while the clock is stretched. This happens after an extension code, and after a data byte with the early wait point. The bench reaches it by holding the stretch for many cycles and changing the acknowledge enable inside that window before pulsing release. The 9th-clock acknowledge must then follow the new value and not the one present at the 8th edge. A repeated start inserted after four bits of a byte, followed by a full matching address, exercises the abort path.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2
    } phase_e;

    localparam int          CNT_W      = 4;
    localparam int          EXT_BITS   = 5;
    localparam logic [4:0]  EXT_PREFIX = 5'b11110;
endpackage

// File: rtl/i2cw_line_sync.sv
module i2cw_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det,
    output logic sda_s
);
    logic [1:0] raw;
    logic [1:0] sync_v;
    logic [1:0] prev_d, prev_q;

    assign raw = {scl_i, sda_i};

    generate
        for (genvar g = 0; g < 2; g++) begin : g_line
            logic [STAGES-1:0] chain_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= {chain_q[STAGES-2:0], raw[g]};
            end
            assign sync_v[g] = chain_q[STAGES-1];
        end
    endgenerate

    always_comb begin
        prev_d = sync_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 2'b11;
        else        prev_q <= prev_d;
    end

    assign sda_s     = sync_v[0];
    assign scl_rise  = sync_v[1] & ~prev_q[1];
    assign scl_fall  = ~sync_v[1] & prev_q[1];
    assign start_det = sync_v[1] & prev_q[1] & prev_q[0] & ~sync_v[0];
    assign stop_det  = sync_v[1] & prev_q[1] & ~prev_q[0] & sync_v[0];
endmodule

// File: rtl/i2cw_addr_match.sv
module i2cw_addr_match
    import i2cw_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic [ADDR_W:0]   byte_i,
    input  logic [ADDR_W-1:0] local_i,
    output logic              hit_o,
    output logic              ext_o
);
    always_comb begin
        ext_o = (byte_i[ADDR_W -: EXT_BITS] == EXT_PREFIX);
        hit_o = (byte_i[ADDR_W:1] == local_i) && !byte_i[0] && !ext_o;
    end
endmodule

// File: rtl/i2cw_byte_ctrl.sv
module i2cw_byte_ctrl
    import i2cw_pkg::*;
#(
    parameter int ADDR_W = 7,
    localparam int BYTE_W = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              if_enable,
    input  logic              wait_on_ninth,
    input  logic              ack_enable,
    input  logic              stop_irq_enable,
    input  logic [ADDR_W-1:0] local_addr,
    input  logic              release_i,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              sda_s,
    output logic              hold_o,
    output logic              ack_o,
    output logic              irq_o,
    output logic [BYTE_W-1:0] rx_o
);
    localparam logic [CNT_W-1:0] FALL_8 = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] FALL_9 = CNT_W'(BYTE_W + 1);

    typedef struct packed {
        phase_e            phase;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] shreg;
        logic [BYTE_W-1:0] rx;
        logic              hit;
        logic              late;
        logic              ack;
        logic              hold;
        logic              ack_pend;
        logic              irq;
    } st_t;

    st_t st_d, st_q;
    logic addr_hit, addr_ext;

    i2cw_addr_match #(.ADDR_W(ADDR_W)) match_i (
        .byte_i  (st_q.shreg),
        .local_i (local_addr),
        .hit_o   (addr_hit),
        .ext_o   (addr_ext)
    );

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (!if_enable) begin
            st_d = '0;
        end else if (start_det) begin
            st_d.phase    = PH_ADDR;
            st_d.cnt      = '0;
            st_d.ack      = 1'b0;
            st_d.hold     = 1'b0;
            st_d.ack_pend = 1'b0;
        end else if (stop_det) begin
            st_d.phase    = PH_IDLE;
            st_d.cnt      = '0;
            st_d.ack      = 1'b0;
            st_d.hold     = 1'b0;
            st_d.ack_pend = 1'b0;
            st_d.irq      = stop_irq_enable;
        end else begin
            if (release_i && st_q.hold) begin
                st_d.hold = 1'b0;
                if (st_q.ack_pend) begin
                    st_d.ack      = ack_enable;
                    st_d.ack_pend = 1'b0;
                end
            end
            if (st_q.phase != PH_IDLE) begin
                if (scl_rise) begin
                    if (st_q.cnt < FALL_8) st_d.shreg = {st_q.shreg[BYTE_W-2:0], sda_s};
                    st_d.cnt = st_q.cnt + 1'b1;
                end else if (scl_fall && st_q.cnt == FALL_8) begin
                    st_d.rx = st_q.shreg;
                    if (st_q.phase == PH_ADDR) begin
                        st_d.hit = addr_hit;
                        if (addr_ext) begin
                            st_d.hold     = 1'b1;
                            st_d.irq      = 1'b1;
                            st_d.ack_pend = 1'b1;
                        end else if (addr_hit) begin
                            st_d.ack = 1'b1;
                        end else begin
                            st_d.phase = PH_IDLE;
                            st_d.cnt   = '0;
                        end
                    end else begin
                        st_d.late = wait_on_ninth;
                        if (wait_on_ninth) begin
                            st_d.ack = ack_enable;
                        end else begin
                            st_d.hold     = 1'b1;
                            st_d.irq      = 1'b1;
                            st_d.ack_pend = 1'b1;
                        end
                    end
                end else if (scl_fall && st_q.cnt == FALL_9) begin
                    st_d.cnt = '0;
                    st_d.ack = 1'b0;
                    if ((st_q.phase == PH_ADDR && st_q.hit) ||
                        (st_q.phase == PH_DATA && st_q.late)) begin
                        st_d.hold = 1'b1;
                        st_d.irq  = 1'b1;
                    end
                    st_d.phase = PH_DATA;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hold_o = st_q.hold;
    assign ack_o  = st_q.ack;
    assign irq_o  = st_q.irq;
    assign rx_o   = st_q.rx;
endmodule

// File: rtl/i2c_slave_waitack.sv
module i2c_slave_waitack #(
    parameter int ADDR_W      = 7,
    parameter int SYNC_STAGES = 2,
    localparam int BYTE_W     = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              if_enable,
    input  logic              wait_on_ninth,
    input  logic              ack_enable,
    input  logic              stop_irq_enable,
    input  logic [ADDR_W-1:0] local_addr,
    input  logic              release_i,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_drive_low_o,
    output logic              sda_drive_low_o,
    output logic              irq_o,
    output logic [BYTE_W-1:0] rx_byte_o
);
    logic scl_rise, scl_fall, start_det, stop_det, sda_s;

    i2cw_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_s     (sda_s)
    );

    i2cw_byte_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .if_enable       (if_enable),
        .wait_on_ninth   (wait_on_ninth),
        .ack_enable      (ack_enable),
        .stop_irq_enable (stop_irq_enable),
        .local_addr      (local_addr),
        .release_i       (release_i),
        .scl_rise        (scl_rise),
        .scl_fall        (scl_fall),
        .start_det       (start_det),
        .stop_det        (stop_det),
        .sda_s           (sda_s),
        .hold_o          (scl_drive_low_o),
        .ack_o           (sda_drive_low_o),
        .irq_o           (irq_o),
        .rx_o            (rx_byte_o)
    );
endmodule

// File: rtl/i2cw_checker.sv
module i2cw_checker (
    input logic clk,
    input logic rst_n,
    input logic if_enable,
    input logic release_i,
    input logic scl_drive_low_o,
    input logic sda_drive_low_o,
    input logic irq_o
);
    assert_hold_until_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_drive_low_o && !release_i && if_enable) |=> scl_drive_low_o);

    assert_stretch_has_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_drive_low_o) |-> irq_o);

    assert_irq_single_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !if_enable |=> (!scl_drive_low_o && !sda_drive_low_o && !irq_o));

    assert_no_double_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(scl_drive_low_o && sda_drive_low_o));
endmodule

bind i2c_slave_waitack i2cw_checker chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .if_enable       (if_enable),
    .release_i       (release_i),
    .scl_drive_low_o (scl_drive_low_o),
    .sda_drive_low_o (sda_drive_low_o),
    .irq_o           (irq_o)
);

// File: tb/i2c_slave_waitack_tb.sv
module i2c_slave_waitack_tb_top;
    localparam logic [6:0] LOCAL = 7'h2A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic if_enable = 1'b0, wait_on_ninth = 1'b0, ack_enable = 1'b0, stop_irq_enable = 1'b0;
    logic release_i = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic scl_drive_low_o, sda_drive_low_o, irq_o;
    logic [7:0] rx_byte_o;
    logic scl_bus, sda_bus;

    int checks = 0, fails = 0, settle = 0, irq_cnt = 0, irq_exp = 0, bphase = 0;
    logic exp_scl = 1'b0, exp_sda = 1'b0, mon_on = 1'b0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    assign scl_bus = scl_m & ~scl_drive_low_o;
    assign sda_bus = sda_m & ~sda_drive_low_o;

    i2c_slave_waitack dut_i (
        .clk (clk), .rst_n (rst_n), .if_enable (if_enable),
        .wait_on_ninth (wait_on_ninth), .ack_enable (ack_enable),
        .stop_irq_enable (stop_irq_enable), .local_addr (LOCAL),
        .release_i (release_i), .scl_i (scl_bus), .sda_i (sda_bus),
        .scl_drive_low_o (scl_drive_low_o), .sda_drive_low_o (sda_drive_low_o),
        .irq_o (irq_o), .rx_byte_o (rx_byte_o)
    );

    always @(posedge clk) if (rst_n && irq_o) irq_cnt++;

    // per-clock comparison of the bus drives against the model's expectation
    always @(negedge clk) begin
        if (mon_on) begin
            if (settle > 0) settle--;
            else begin
                checks++;
                if (scl_drive_low_o !== exp_scl || sda_drive_low_o !== exp_sda) begin
                    fails++;
                    $display("FAIL %s: drives scl=%b sda=%b expected scl=%b sda=%b",
                             cur_req, scl_drive_low_o, sda_drive_low_o, exp_scl, exp_sda);
                end
            end
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_exp(input logic s, input logic d);
        exp_scl = s; exp_sda = d; settle = 6;
    endtask

    task automatic check_val(input int act, input int expv, input string req);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic pulse_release();
        @(negedge clk) release_i = 1'b1;
        @(negedge clk) release_i = 1'b0;
    endtask

    task automatic do_start(input string req);
        cur_req = req;
        set_exp(1'b0, 1'b0);
        sda_m = 1'b1; wait_n(3);
        scl_m = 1'b1; wait_n(6);
        sda_m = 1'b0; wait_n(6);
        scl_m = 1'b0; wait_n(6);
        bphase = if_enable ? 1 : 0;
        check_val(irq_cnt, irq_exp, req);
    endtask

    task automatic do_stop(input string req);
        cur_req = req;
        set_exp(1'b0, 1'b0);
        sda_m = 1'b0; wait_n(3);
        scl_m = 1'b1; wait_n(6);
        sda_m = 1'b1; wait_n(8);
        if (if_enable && stop_irq_enable) irq_exp++;
        check_val(irq_cnt, irq_exp, req);
        bphase = 0;
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; wait_n(3);
            scl_m = 1'b1; wait_n(6);
            scl_m = 1'b0; wait_n(4);
        end
    endtask

    // behavioural reference: decides wait point, irq point and ack from the rules
    task automatic send_byte(input logic [7:0] b, input logic ae_rel, input string req);
        logic w8, w9p, ackv, early, hit, ext;
        int nxt;
        cur_req = req;
        w8 = 0; w9p = 0; ackv = 0; early = 0; nxt = bphase;
        hit = (b[7:1] == LOCAL) && !b[0] && (b[7:3] != 5'b11110);
        ext = (b[7:3] == 5'b11110);
        if (if_enable && bphase == 1) begin
            if (ext) begin w8 = 1; ackv = ae_rel; nxt = 2; end
            else if (hit) begin early = 1; ackv = 1; w9p = 1; nxt = 2; end
            else nxt = 0;
        end else if (if_enable && bphase == 2) begin
            if (!wait_on_ninth) begin w8 = 1; ackv = ae_rel; end
            else begin early = 1; ackv = ack_enable; w9p = 1; end
        end
        send_bits(b, 7);
        sda_m = b[0]; wait_n(3);
        scl_m = 1'b1; wait_n(6);
        set_exp(w8, early ? ackv : 1'b0);
        scl_m = 1'b0; wait_n(8);
        if (w8) begin
            irq_exp++;
            check_val(irq_cnt, irq_exp, req);
            wait_n(24);
            ack_enable = ae_rel;
            set_exp(1'b0, ackv);
            pulse_release();
            wait_n(6);
        end
        if (if_enable && bphase != 0) check_val(int'(rx_byte_o), int'(b), {req, "/R11"});
        sda_m = 1'b1; wait_n(3);
        scl_m = 1'b1; wait_n(6);
        set_exp(w9p, 1'b0);
        scl_m = 1'b0; wait_n(8);
        if (w9p) irq_exp++;
        check_val(irq_cnt, irq_exp, req);
        if (w9p) begin
            wait_n(16);
            set_exp(1'b0, 1'b0);
            pulse_release();
            wait_n(6);
        end
        bphase = nxt;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not complete");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        wait_n(4);
        rst_n = 1'b1;
        wait_n(2);
        // R1: reset state
        check_val(int'(scl_drive_low_o), 0, "R1");
        check_val(int'(sda_drive_low_o), 0, "R1");
        check_val(int'(rx_byte_o), 0, "R1");
        if_enable = 1'b1;
        mon_on = 1'b1;
        wait_n(4);

        // R2: matching address, ack enable and wait select both 0
        do_start("R1");
        send_byte({LOCAL, 1'b0}, 1'b0, "R2");
        // R5: early wait point, ack decided at release
        wait_on_ninth = 1'b0; ack_enable = 1'b0;
        send_byte(8'hA5, 1'b1, "R5");
        send_byte(8'h5A, 1'b0, "R5");
        // R6: late wait point
        wait_on_ninth = 1'b1; ack_enable = 1'b0;
        send_byte(8'h3C, 1'b0, "R6");
        ack_enable = 1'b1;
        send_byte(8'h81, 1'b1, "R6");
        stop_irq_enable = 1'b1;
        do_stop("R8");

        // R3: mismatch ignored until next start; stop without irq enable
        wait_on_ninth = 1'b0; ack_enable = 1'b1;
        do_start("R1");
        send_byte({7'h22, 1'b0}, 1'b1, "R3");
        send_byte(8'hFF, 1'b1, "R3");
        send_byte(8'h00, 1'b1, "R3");
        stop_irq_enable = 1'b0;
        do_stop("R8");

        // R4: extension code, ack enable set only during the wait
        ack_enable = 1'b0; wait_on_ninth = 1'b1;
        do_start("R1");
        send_byte(8'hF0, 1'b1, "R4");
        send_byte(8'h6E, 1'b1, "R4");
        ack_enable = 1'b1;
        do_start("R1");
        send_byte(8'hF3, 1'b0, "R4");
        ack_enable = 1'b0;
        do_stop("R8");

        // R10: repeated start after four bits, then full matching address
        wait_on_ninth = 1'b1;
        do_start("R10");
        cur_req = "R10";
        send_bits({LOCAL, 1'b0}, 4);
        do_start("R10");
        send_byte({LOCAL, 1'b0}, 1'b0, "R10");
        send_byte(8'h12, 1'b0, "R10");
        stop_irq_enable = 1'b1;
        do_stop("R8");

        // R9: disabled interface ignores a full matching transfer
        if_enable = 1'b0;
        set_exp(1'b0, 1'b0);
        wait_n(4);
        do_start("R9");
        send_byte({LOCAL, 1'b0}, 1'b1, "R9");
        send_byte(8'h77, 1'b1, "R9");
        do_stop("R9");
        check_val(irq_cnt, irq_exp, "R9");

        wait_n(10);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule